// File: doc/BRIEF.md
# SMBus Register Slave Engine

This block is the serial slave front end of a small sensor chip. It watches an oversampled two-wire clock/data pair and recognises START, repeated START and STOP. It accepts a 7-bit slave address built from a fixed 4-bit preamble and three strap pins. Accepted traffic moves 16-bit words between the bus and an external register-file port, most significant byte first.

An 8-bit register pointer selects the word. A write transaction loads the pointer and may carry two data bytes, which are handed to the register file in one pulse after the closing STOP. A write that carries only the pointer byte, followed by a repeated START and a read address, reads from the new location. Reads stream the selected word for as long as the master keeps acknowledging. A clock-low timer aborts a stalled transaction and releases the data line.

The data line is only ever pulled low, through an active-high pull-down enable. The register contents, analog glitch filtering and clock stretching lie outside this block.

Top module: `smb_reg_slave`

## Requirements
- R1: An address byte is accepted only when bits [7:4] equal 4'b0011 and bits [3:1] equal `strapAddr`. Bit 0 set to 1 means read and 0 means write. A mismatching address gets no ACK, and the following bytes are ignored until the next START or STOP.
- R2: Every accepted byte sent by the master is acknowledged by asserting `sdaDriveLow` during the 9th clock of that byte.
- R3: `regAddr` (the pointer) is 0x00 after reset. It is loaded from the byte that follows a write address and keeps its value across transactions.
- R4: A read address returns the word `regRdData` at the current pointer, bits [15:8] first and then bits [7:0], each MSB first. Output bits change only after SCL falling edges.
- R5: A write carries address, pointer, data MSB byte and data LSB byte. The word is presented on `regWrData` with a one-cycle `regWrEn` pulse only after the STOP, never before it.
- R6: A write that has only one data byte before STOP produces no `regWrEn` pulse.
- R7: A pointer-only write, followed by a repeated START and a read address, reads the word at the newly loaded pointer.
- R8: After an LSB byte that the master ACKs, the MSB byte of the same word is sent again. After a master NACK the block stops driving until the next START.
- R9: A third data byte in one write is not acknowledged, and the first two bytes are still committed at STOP.
- R10: Between START and STOP, if SCL stays low for more than `TIMEOUT_CYC` clock cycles, the block returns to idle, releases SDA and drops any pending write. The timer restarts on every SCL falling edge, so shorter low phases keep the transaction alive.
- R11: During and right after reset, `sdaDriveLow` and `regWrEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw serial clock line |
| sdaIn | input | 1 | Raw serial data line (wired bus level) |
| strapAddr | input | 3 | Strap pins forming address bits [3:1] |
| sdaDriveLow | output | 1 | 1 = pull the data line low |
| regAddr | output | 8 | Register pointer, read and write address |
| regRdData | input | 16 | Word read from the register file at `regAddr` |
| regWrEn | output | 1 | One-cycle write strobe for the register file |
| regWrData | output | 16 | Word to write at `regAddr` |

## Verification
The clock-low timer's restart on an SCL falling edge and its expiry compete for the same counter. Which one wins decides whether a transaction survives a long low phase. The bench stretches the low phase to just under the limit between two data bytes and expects the word to commit. It then holds SCL low well past the limit during an ACK and expects the pull-down to drop inside the window and the later STOP to commit nothing.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [3:0] ADDR_PREAMBLE = 4'b0011;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_PTR, PH_WDATA, PH_READ, PH_SKIP
  } phase_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftIn;    // capture one received bit
    logic ptrLoad;    // pointer <= received byte
    logic wrHiLoad;   // write buffer MSB byte
    logic wrLoLoad;   // write buffer LSB byte
    logic wordLatch;  // latch read word, load its MSB byte to transmit
    logic txLoadLo;   // load latched LSB byte to transmit
    logic txLoadHi;   // load latched MSB byte to transmit
    logic txShift;    // advance transmit bit
    logic commit;     // fire register write
  } dpStrobe_t;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineLvl,
  output logic lineRise,
  output logic lineFall
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic [2:0]             winQ;
  logic                   lvlQ;
  logic                   prevQ;
  logic                   majority;

  assign majority = (winQ[0] & winQ[1]) | (winQ[0] & winQ[2]) | (winQ[1] & winQ[2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      winQ  <= '1;
      lvlQ  <= 1'b1;
      prevQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      winQ  <= {winQ[1:0], syncQ[SYNC_STAGES-1]};
      lvlQ  <= majority;
      prevQ <= lvlQ;
    end
  end

  assign lineLvl  = lvlQ;
  assign lineRise = lvlQ & ~prevQ;
  assign lineFall = ~lvlQ & prevQ;
endmodule

// File: rtl/smb_dpath.sv
module smb_dpath
  import smb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaBit,
  input  logic [WORD_W-1:0] regRdData,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [BYTE_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [WORD_W-1:0] regWrData
);
  logic [BYTE_W-1:0] rxQ, ptrQ, txQ;
  logic [WORD_W-1:0] wrBufQ, rdWordQ;
  logic              wrEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxQ     <= '0;
      ptrQ    <= '0;
      txQ     <= '1;
      wrBufQ  <= '0;
      rdWordQ <= '0;
      wrEnQ   <= 1'b0;
    end else begin
      if (stb.shiftIn)  rxQ <= {rxQ[BYTE_W-2:0], sdaBit};
      if (stb.ptrLoad)  ptrQ <= rxQ;
      if (stb.wrHiLoad) wrBufQ[WORD_W-1:BYTE_W] <= rxQ;
      if (stb.wrLoLoad) wrBufQ[BYTE_W-1:0] <= rxQ;
      if (stb.wordLatch) begin
        rdWordQ <= regRdData;
        txQ     <= regRdData[WORD_W-1:BYTE_W];
      end else if (stb.txLoadLo) begin
        txQ <= rdWordQ[BYTE_W-1:0];
      end else if (stb.txLoadHi) begin
        txQ <= rdWordQ[WORD_W-1:BYTE_W];
      end else if (stb.txShift) begin
        txQ <= {txQ[BYTE_W-2:0], 1'b1};
      end
      wrEnQ <= stb.commit;
    end
  end

  assign rxByte    = rxQ;
  assign txMsb     = txQ[BYTE_W-1];
  assign regAddr   = ptrQ;
  assign regWrEn   = wrEnQ;
  assign regWrData = wrBufQ;
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclLvl,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaLvl,
  input  logic              sdaRise,
  input  logic              sdaFall,
  input  logic [2:0]        strapAddr,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output dpStrobe_t         stb,
  output logic              sdaDriveLow,
  output logic              busy,
  output logic              ackPhase
);
  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYC - 1);
  localparam logic [3:0] LAST_BIT = 4'd8;

  phase_t          phase;
  logic            busyQ, ackPhaseQ, ackDrive, txActive;
  logic            rdReq, rdLsb, mstAck;
  logic [3:0]      bitCnt;
  logic [1:0]      wrCnt;
  logic [TO_W-1:0] toCnt;
  logic            startDet, stopDet, timeoutHit, addrHit, byteEnd;

  assign startDet   = sclLvl & sdaFall;
  assign stopDet    = sclLvl & sdaRise;
  assign timeoutHit = busyQ & ~sclLvl & (toCnt == TO_LAST);
  assign addrHit    = (rxByte[7:4] == ADDR_PREAMBLE) && (rxByte[3:1] == strapAddr);
  assign byteEnd    = sclFall & ~ackPhaseQ & (bitCnt == LAST_BIT);

  always_comb begin
    stb = '0;
    if (timeoutHit) begin
      stb = '0;
    end else if (stopDet) begin
      stb.commit = busyQ && (wrCnt == 2'd2);
    end else if (!startDet && busyQ) begin
      if (sclRise && !ackPhaseQ && bitCnt != LAST_BIT &&
          (phase == PH_ADDR || phase == PH_PTR || phase == PH_WDATA))
        stb.shiftIn = 1'b1;
      if (byteEnd) begin
        if (phase == PH_PTR) stb.ptrLoad = 1'b1;
        if (phase == PH_WDATA && wrCnt == 2'd0) stb.wrHiLoad = 1'b1;
        if (phase == PH_WDATA && wrCnt == 2'd1) stb.wrLoLoad = 1'b1;
      end else if (sclFall && ackPhaseQ) begin
        if (phase == PH_ADDR && rdReq) stb.wordLatch = 1'b1;
        if (phase == PH_READ && mstAck) begin
          stb.txLoadLo = rdLsb;
          stb.txLoadHi = ~rdLsb;
        end
      end else if (sclFall && phase == PH_READ && txActive && bitCnt != 4'd0) begin
        stb.txShift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0; phase <= PH_IDLE; bitCnt <= '0; ackPhaseQ <= 1'b0;
      ackDrive <= 1'b0; txActive <= 1'b0; rdReq <= 1'b0; rdLsb <= 1'b0;
      mstAck <= 1'b0; wrCnt <= '0; toCnt <= '0;
    end else if (timeoutHit || stopDet) begin
      busyQ <= 1'b0; phase <= PH_IDLE; bitCnt <= '0; ackPhaseQ <= 1'b0;
      ackDrive <= 1'b0; txActive <= 1'b0; wrCnt <= '0; toCnt <= '0;
    end else if (startDet) begin
      busyQ <= 1'b1; phase <= PH_ADDR; bitCnt <= '0; ackPhaseQ <= 1'b0;
      ackDrive <= 1'b0; txActive <= 1'b0; wrCnt <= '0; toCnt <= '0;
    end else if (busyQ) begin
      if (sclFall)      toCnt <= '0;
      else if (!sclLvl) toCnt <= toCnt + TO_W'(1);
      if (sclRise) begin
        if (ackPhaseQ)              mstAck <= ~sdaLvl;
        else if (bitCnt != LAST_BIT) bitCnt <= bitCnt + 4'd1;
      end
      if (byteEnd) begin
        case (phase)
          PH_ADDR: begin
            if (addrHit) begin
              ackPhaseQ <= 1'b1; ackDrive <= 1'b1; rdReq <= rxByte[0];
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_PTR: begin ackPhaseQ <= 1'b1; ackDrive <= 1'b1; end
          PH_WDATA: begin
            if (wrCnt != 2'd2) begin
              ackPhaseQ <= 1'b1; ackDrive <= 1'b1; wrCnt <= wrCnt + 2'd1;
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_READ: begin ackPhaseQ <= 1'b1; txActive <= 1'b0; end
          default: ;
        endcase
      end else if (sclFall && ackPhaseQ) begin
        ackPhaseQ <= 1'b0; bitCnt <= '0; ackDrive <= 1'b0;
        case (phase)
          PH_ADDR: begin
            if (rdReq) begin phase <= PH_READ; txActive <= 1'b1; rdLsb <= 1'b1; end
            else       phase <= PH_PTR;
          end
          PH_PTR: phase <= PH_WDATA;
          PH_READ: begin
            if (mstAck) begin txActive <= 1'b1; rdLsb <= ~rdLsb; end
            else        phase <= PH_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaDriveLow = ackDrive | (txActive & ~txMsb);
  assign busy        = busyQ;
  assign ackPhase    = ackPhaseQ;

  // R10: the low-phase counter never reaches the limit without aborting
  a_r10_timer_bound: assert property (@(posedge clk) disable iff (!rstN)
    toCnt < TO_W'(TIMEOUT_CYC));
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  strapAddr,
  output logic        sdaDriveLow,
  output logic [7:0]  regAddr,
  input  logic [15:0] regRdData,
  output logic        regWrEn,
  output logic [15:0] regWrData
);
  localparam int LINE_N = 2;  // index 0 = clock, 1 = data

  logic [LINE_N-1:0] rawLine, lvl, rise, fall;
  dpStrobe_t         stb;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb, busy, ackPhase;

  assign rawLine = {sdaIn, sclIn};

  for (genvar g = 0; g < LINE_N; g++) begin : g_filt
    smb_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk(clk), .rstN(rstN), .lineIn(rawLine[g]),
      .lineLvl(lvl[g]), .lineRise(rise[g]), .lineFall(fall[g]));
  end

  smb_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclLvl(lvl[0]), .sclRise(rise[0]), .sclFall(fall[0]),
    .sdaLvl(lvl[1]), .sdaRise(rise[1]), .sdaFall(fall[1]),
    .strapAddr(strapAddr), .rxByte(rxByte), .txMsb(txMsb),
    .stb(stb), .sdaDriveLow(sdaDriveLow), .busy(busy), .ackPhase(ackPhase));

  smb_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(lvl[1]),
    .regRdData(regRdData), .rxByte(rxByte), .txMsb(txMsb),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData));

  // R5: a register write follows a STOP seen one cycle earlier
  a_r5_commit_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $past(lvl[0] && rise[1]));
  // R2: the pull-down only starts while the filtered clock is low
  a_r2_drive_in_low_phase: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !lvl[0]);
  // R10: outside a transaction the data line is released
  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sdaDriveLow);
  // R3: the pointer moves only when a byte is being acknowledged
  a_r3_ptr_moves_in_ack: assert property (@(posedge clk) disable iff (!rstN)
    $changed(regAddr) |-> ackPhase);
endmodule

// File: tb/tb_smb_reg_slave.sv
module tb_smb_reg_slave;
  localparam int TO_CYC = 200;
  localparam int Q = 16;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] ADDR_W = {4'b0011, STRAP, 1'b0};
  localparam logic [7:0] ADDR_R = {4'b0011, STRAP, 1'b1};
  localparam int NV = 4;
  localparam logic [23:0] VEC [NV] = '{24'h05_1234, 24'h00_FFFF, 24'hFF_8001, 24'h3C_0000};

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1;
  logic sdaDriveLow, regWrEn;
  logic [7:0] regAddr, lastAddr;
  logic [15:0] regRdData, regWrData, lastData;
  logic [15:0] rf [256];
  int wrCount = 0, checks = 0, errors = 0, cyc = 0;
  wire busSda = sdaM & ~sdaDriveLow;

  always #10 clk = ~clk;

  smb_reg_slave #(.TIMEOUT_CYC(TO_CYC)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(busSda), .strapAddr(STRAP),
    .sdaDriveLow(sdaDriveLow), .regAddr(regAddr), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrData(regWrData));

  function automatic logic [15:0] initVal(input logic [7:0] a);
    return {a, ~a};
  endfunction

  assign regRdData = rf[regAddr];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) rf[i] <= initVal(8'(i));
    end else if (regWrEn) begin
      rf[regAddr] <= regWrData;
      wrCount <= wrCount + 1;
      lastAddr <= regAddr;
      lastData <= regWrData;
    end
  end

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      finishRun();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clkBit(input logic drv, output logic seen);
    sdaM = drv; wt(Q);
    sclM = 1'b1; wt(Q / 2);
    seen = busSda; wt(Q / 2);
    sclM = 1'b0;
  endtask

  task automatic startC();
    sdaM = 1'b1; wt(Q); sclM = 1'b1; wt(Q); sdaM = 1'b0; wt(Q); sclM = 1'b0;
  endtask

  task automatic stopC();
    sdaM = 1'b0; wt(Q); sclM = 1'b1; wt(Q); sdaM = 1'b1; wt(Q);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clkBit(b[i], s);
    clkBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clkBit(1'b1, s); b[i] = s; end
    clkBit(~giveAck, s);
  endtask

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] hi, lo, b2, b3;
    int w;
    wt(5); rstN = 1'b1; wt(10);
    // R11 reset state, R3 pointer reset value
    chk("R11 drive after reset", 32'(sdaDriveLow), 0);
    chk("R11 wrEn after reset", 32'(regWrEn), 0);
    chk("R3 pointer reset", 32'(regAddr), 0);

    // R4 immediate read at pointer 0
    startC(); writeByte(ADDR_R, a0); readByte(1'b1, hi); readByte(1'b0, lo); stopC();
    chk("R1 read address ack", 32'(a0), 1);
    chk("R4 immediate read", {hi, lo}, initVal(8'h00));

    // R1 wrong strap and wrong preamble
    startC(); writeByte({4'b0011, 3'b010, 1'b0}, a0); writeByte(8'h22, a1); stopC();
    chk("R1 wrong strap nack", 32'(a0), 0);
    chk("R1 following byte ignored", 32'(a1), 0);
    chk("R1 pointer untouched", 32'(regAddr), 0);
    startC(); writeByte({4'b0111, STRAP, 1'b0}, a0); stopC();
    chk("R1 wrong preamble nack", 32'(a0), 0);

    // table: full write, then selective read elsewhere, then immediate read
    for (int v = 0; v < NV; v++) begin
      logic [7:0] p, q;
      logic [15:0] d;
      p = VEC[v][23:16]; d = VEC[v][15:0]; q = p ^ 8'h80;
      w = wrCount;
      startC(); writeByte(ADDR_W, a0); writeByte(p, a1);
      writeByte(d[15:8], a2); writeByte(d[7:0], a3);
      chk("R2 write acks", {a0, a1, a2, a3}, 4'hF);
      wt(10);
      chk("R5 no write before STOP", wrCount, w);
      stopC(); wt(4);
      chk("R5 write count", wrCount, w + 1);
      chk("R5 write address", 32'(lastAddr), 32'(p));
      chk("R5 write data", 32'(lastData), 32'(d));
      startC(); writeByte(ADDR_W, a0); writeByte(q, a1);
      startC(); writeByte(ADDR_R, a2); readByte(1'b1, hi); readByte(1'b0, lo); stopC();
      chk("R7 selective read", {hi, lo}, initVal(q));
      startC(); writeByte(ADDR_R, a0); readByte(1'b1, hi); readByte(1'b0, lo); stopC();
      chk("R3 pointer kept", {hi, lo}, initVal(q));
    end

    // R8 continuation and release after NACK (pointer is 0xBC)
    startC(); writeByte(ADDR_R, a0);
    readByte(1'b1, hi); readByte(1'b1, lo); readByte(1'b0, b2); readByte(1'b0, b3); stopC();
    chk("R4 MSB byte", 32'(hi), 32'(initVal(8'hBC) >> 8));
    chk("R4 LSB byte", 32'(lo), 32'(initVal(8'hBC) & 16'hFF));
    chk("R8 MSB repeated", 32'(b2), 32'(initVal(8'hBC) >> 8));
    chk("R8 released after NACK", 32'(b3), 32'hFF);

    // R6 single data byte discarded
    w = wrCount;
    startC(); writeByte(ADDR_W, a0); writeByte(8'h10, a1); writeByte(8'hAB, a2); stopC(); wt(4);
    chk("R6 no commit", wrCount, w);
    chk("R3 pointer loaded", 32'(regAddr), 32'h10);
    startC(); writeByte(ADDR_R, a0); readByte(1'b1, hi); readByte(1'b0, lo); stopC();
    chk("R6 register unchanged", {hi, lo}, initVal(8'h10));

    // R9 third data byte
    w = wrCount;
    startC(); writeByte(ADDR_W, a0); writeByte(8'h20, a1);
    writeByte(8'h5A, a2); writeByte(8'hC3, a3); writeByte(8'h77, b2[0]); stopC(); wt(4);
    chk("R9 third byte nack", 32'(b2[0]), 0);
    chk("R9 commit count", wrCount, w + 1);
    chk("R9 commit data", 32'(lastData), 32'h5AC3);

    // R10 low phase just under limit keeps the transaction
    w = wrCount;
    startC(); writeByte(ADDR_W, a0); writeByte(8'h30, a1); writeByte(8'h12, a2);
    wt(140);
    writeByte(8'h34, a3); stopC(); wt(4);
    chk("R10 short stretch ack", 32'(a3), 1);
    chk("R10 short stretch commit", wrCount, w + 1);
    chk("R10 short stretch data", 32'(lastData), 32'h1234);

    // R10 timeout during ACK of second data byte
    w = wrCount;
    startC(); writeByte(ADDR_W, a0); writeByte(8'h40, a1); writeByte(8'h99, a2);
    for (int i = 7; i >= 0; i--) clkBit(1'(8'h88 >> i), a3);
    wt(100);
    chk("R2 ack held before timeout", 32'(sdaDriveLow), 1);
    wt(160);
    chk("R10 released after timeout", 32'(sdaDriveLow), 0);
    stopC(); wt(4);
    chk("R10 pending write dropped", wrCount, w);
    startC(); writeByte(ADDR_R, a0); readByte(1'b1, hi); readByte(1'b0, lo); stopC();
    chk("R10 recovers after timeout", {hi, lo}, initVal(8'h40));
    chk("R11 idle drive", 32'(sdaDriveLow), 0);

    finishRun();
  end
endmodule